// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block turns one load/store-multiple request into an ordered series of word transfers. A request gives a base address, a 16-bit mask that selects registers, an addressing mode, a direction flag (load or store) and a writeback flag. The block works out the lowest byte address that the group touches. It then sends the whole group to the bus as one incrementing burst of word-sized beats. This way the per-access bus overhead is paid once for the group, not once per word.

Whatever the mode, the transfers always run upward in memory. The selected register with the smallest index takes the lowest address, and each further beat takes the next selected index and the next word. The four base modes (increment or decrement, applied before or after each transfer) and four stack-style aliases all reduce to a start address and a length. For the aliases, the meaning depends on whether the request is a load or a store. When writeback is requested, the block also reports the moved base. A request with no register selected is refused with an error pulse.

Top module: `lsm_addr_seq`

## Requirements
- R1: `req_ready` is high exactly when no burst is in progress. After a request is accepted, `req_ready` stays low until the cycle after the final beat's `beat_valid && beat_ready` edge.
- R2: The four base modes on `req_mode` start the burst at the following addresses, where B is the aligned base and N is the number of set mask bits:
  - code 0, increment-after: B
  - code 1, increment-before: B+4
  - code 2, decrement-after: B-4N+4
  - code 3, decrement-before: B-4N
- R3: The stack aliases select a base mode from the direction flag, with `req_load`=1 meaning load:
  - code 4, full-descending: increment-after for a load, decrement-before for a store.
  - code 5, empty-descending: increment-before for a load, decrement-after for a store.
  - code 6, full-ascending: decrement-after for a load, increment-before for a store.
  - code 7, empty-ascending: decrement-before for a load, increment-after for a store.
- R4: Beats carry the selected register indices in ascending order. The first beat's address equals `burst_addr`, and each following beat's address is 4 higher.
- R5: One cycle after acceptance, `burst_valid` pulses high for one cycle. With it come `burst_addr` (the start address), `burst_len` = N and `burst_load` equal to the request's direction. The first beat is valid in that same cycle.
- R6: When `req_wb` is set, `wb_valid` pulses together with `burst_valid`. `wb_base` is then B+4N for the increment modes, or B-4N for the decrement modes. When `req_wb` is clear, `wb_valid` stays low.
- R7: `beat_last` is high on the final beat only. After that beat is taken, `beat_valid` drops.
- R8: A request with an all-zero mask produces an `err_valid` pulse one cycle after acceptance, and no burst, no beat and no writeback. The block stays ready.
- R9: Bits 1:0 of `req_base` are treated as zero in every computed address.
- R10: While `beat_valid` is high and `beat_ready` is low, `beat_reg`, `beat_addr` and `beat_last` hold their values.
- R11: After reset, `req_ready` is high and `burst_valid`, `beat_valid`, `wb_valid` and `err_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_base | input | 32 | Base address |
| req_mask | input | 16 | Register-select mask |
| req_mode | input | 3 | Addressing mode code (0-7) |
| req_load | input | 1 | 1 = load, 0 = store |
| req_wb | input | 1 | Writeback of the moved base requested |
| burst_valid | output | 1 | One-cycle burst request pulse |
| burst_addr | output | 32 | Lowest address of the burst |
| burst_len | output | 5 | Beat count of the burst |
| burst_load | output | 1 | Direction of the burst |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Beat taken by the bus side |
| beat_reg | output | 4 | Register index of the beat |
| beat_addr | output | 32 | Word address of the beat |
| beat_last | output | 1 | Final beat of the burst |
| wb_valid | output | 1 | Updated base valid (one-cycle pulse) |
| wb_base | output | 32 | Updated base value |
| err_valid | output | 1 | Empty-mask rejection pulse |

## Verification
The burst request, the writeback result and the error pulse are all registered at the acceptance edge. The first beat is also registered there, so all of them are due in the first cycle after the handshake. The bench drives every input on the falling edge and reads those results on the next falling edge. After that, each beat moves only at an edge where `beat_ready` was high. The bench therefore advances its expected index and address only after a falling-edge sample in which it had raised `beat_ready`, and a stalled cycle must show the same beat again. `req_ready` is expected back on the falling edge that follows the final beat's handshake.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  // Requested addressing mode as encoded on the request port
  typedef enum logic [2:0] {
    MODE_INC_AFTER  = 3'd0,
    MODE_INC_BEFORE = 3'd1,
    MODE_DEC_AFTER  = 3'd2,
    MODE_DEC_BEFORE = 3'd3,
    MODE_STK_FULL_DN  = 3'd4,
    MODE_STK_EMPTY_DN = 3'd5,
    MODE_STK_FULL_UP  = 3'd6,
    MODE_STK_EMPTY_UP = 3'd7
  } lsm_mode_e;

  // Resolved base mode after alias mapping
  typedef enum logic [1:0] {
    BM_INC_AFTER  = 2'd0,
    BM_INC_BEFORE = 2'd1,
    BM_DEC_AFTER  = 2'd2,
    BM_DEC_BEFORE = 2'd3
  } lsm_base_e;

endpackage

// File: rtl/lsm_mode_decode.sv
module lsm_mode_decode
  import lsm_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       load_i,
  output lsm_base_e  bmode_o
);

  lsm_mode_e mode;
  assign mode = lsm_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_INC_AFTER:    bmode_o = BM_INC_AFTER;
      MODE_INC_BEFORE:   bmode_o = BM_INC_BEFORE;
      MODE_DEC_AFTER:    bmode_o = BM_DEC_AFTER;
      MODE_DEC_BEFORE:   bmode_o = BM_DEC_BEFORE;
      MODE_STK_FULL_DN:  bmode_o = load_i ? BM_INC_AFTER  : BM_DEC_BEFORE;
      MODE_STK_EMPTY_DN: bmode_o = load_i ? BM_INC_BEFORE : BM_DEC_AFTER;
      MODE_STK_FULL_UP:  bmode_o = load_i ? BM_DEC_AFTER  : BM_INC_BEFORE;
      MODE_STK_EMPTY_UP: bmode_o = load_i ? BM_DEC_BEFORE : BM_INC_AFTER;
      default:           bmode_o = BM_INC_AFTER;
    endcase
  end

endmodule

// File: rtl/lsm_addr_calc.sv
module lsm_addr_calc
  import lsm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int REGS = 16,
  localparam int CNTW = $clog2(REGS + 1)
) (
  input  logic [AW-1:0]   base_i,
  input  logic [REGS-1:0] mask_i,
  input  lsm_base_e       bmode_i,
  output logic [AW-1:0]   start_o,
  output logic [AW-1:0]   next_base_o,
  output logic [CNTW-1:0] count_o,
  output logic            empty_o
);

  localparam logic [AW-1:0] WORD = AW'(4);

  // Running population count, one adder stage per mask bit
  logic [CNTW-1:0] psum [REGS+1];
  assign psum[0] = '0;
  for (genvar g = 0; g < REGS; g++) begin : g_pop
    assign psum[g+1] = psum[g] + CNTW'(mask_i[g]);
  end

  logic [AW-1:0] aligned;
  logic [AW-1:0] span;

  assign count_o = psum[REGS];
  assign empty_o = (count_o == '0);
  assign aligned = base_i & ~AW'(3);
  assign span    = AW'(count_o) << 2;

  always_comb begin
    unique case (bmode_i)
      BM_INC_AFTER:  start_o = aligned;
      BM_INC_BEFORE: start_o = aligned + WORD;
      BM_DEC_AFTER:  start_o = aligned - span + WORD;
      BM_DEC_BEFORE: start_o = aligned - span;
      default:       start_o = aligned;
    endcase
  end

  assign next_base_o = (bmode_i == BM_INC_AFTER || bmode_i == BM_INC_BEFORE)
                       ? aligned + span : aligned - span;

endmodule

// File: rtl/lsm_beat_walker.sv
module lsm_beat_walker #(
  parameter int AW   = 32,
  parameter int REGS = 16,
  localparam int IDXW = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [REGS-1:0] mask_i,
  input  logic [AW-1:0]   start_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [IDXW-1:0] idx_o,
  output logic [AW-1:0]   addr_o,
  output logic            last_o,
  output logic            done_o
);

  logic [REGS-1:0] rem_q;
  logic [REGS-1:0] rem_rest;
  logic            take;

  // Remaining set with the lowest selected register removed
  assign rem_rest = rem_q & (rem_q - REGS'(1));
  assign last_o   = (rem_rest == '0);
  assign take     = valid_o && ready_i;
  assign done_o   = take && last_o;

  always_comb begin
    idx_o = '0;
    for (int i = REGS - 1; i >= 0; i--) begin
      if (rem_q[i]) idx_o = IDXW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      rem_q   <= '0;
      addr_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      rem_q   <= mask_i;
      addr_o  <= start_i;
    end else if (take) begin
      rem_q   <= rem_rest;
      addr_o  <= addr_o + AW'(4);
      if (last_o) valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int REGS = 16,
  localparam int IDXW = $clog2(REGS),
  localparam int CNTW = $clog2(REGS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_base,
  input  logic [REGS-1:0] req_mask,
  input  logic [2:0]      req_mode,
  input  logic            req_load,
  input  logic            req_wb,
  output logic            burst_valid,
  output logic [AW-1:0]   burst_addr,
  output logic [CNTW-1:0] burst_len,
  output logic            burst_load,
  output logic            beat_valid,
  input  logic            beat_ready,
  output logic [IDXW-1:0] beat_reg,
  output logic [AW-1:0]   beat_addr,
  output logic            beat_last,
  output logic            wb_valid,
  output logic [AW-1:0]   wb_base,
  output logic            err_valid
);

  logic            busy_q;
  logic            accept;
  lsm_base_e       bmode;
  logic [AW-1:0]   start;
  logic [AW-1:0]   next_base;
  logic [CNTW-1:0] count;
  logic            empty;
  logic            walk_done;

  assign req_ready = !busy_q;
  assign accept    = req_valid && req_ready;

  lsm_mode_decode u_dec (
    .mode_i  (req_mode),
    .load_i  (req_load),
    .bmode_o (bmode)
  );

  lsm_addr_calc #(.AW(AW), .REGS(REGS)) u_calc (
    .base_i      (req_base),
    .mask_i      (req_mask),
    .bmode_i     (bmode),
    .start_o     (start),
    .next_base_o (next_base),
    .count_o     (count),
    .empty_o     (empty)
  );

  lsm_beat_walker #(.AW(AW), .REGS(REGS)) u_walk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (accept && !empty),
    .mask_i  (req_mask),
    .start_i (start),
    .ready_i (beat_ready),
    .valid_o (beat_valid),
    .idx_o   (beat_reg),
    .addr_o  (beat_addr),
    .last_o  (beat_last),
    .done_o  (walk_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      burst_valid <= 1'b0;
      burst_addr  <= '0;
      burst_len   <= '0;
      burst_load  <= 1'b0;
      wb_valid    <= 1'b0;
      wb_base     <= '0;
      err_valid   <= 1'b0;
    end else begin
      burst_valid <= 1'b0;
      wb_valid    <= 1'b0;
      err_valid   <= 1'b0;
      if (accept) begin
        if (empty) begin
          err_valid <= 1'b1;
        end else begin
          busy_q      <= 1'b1;
          burst_valid <= 1'b1;
          burst_addr  <= start;
          burst_len   <= count;
          burst_load  <= req_load;
          wb_valid    <= req_wb;
          wb_base     <= next_base;
        end
      end else if (walk_done) begin
        busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
  parameter int AW   = 32,
  parameter int REGS = 16,
  localparam int IDXW = $clog2(REGS)
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            burst_valid,
  input logic [AW-1:0]   burst_addr,
  input logic            beat_valid,
  input logic            beat_ready,
  input logic [IDXW-1:0] beat_reg,
  input logic [AW-1:0]   beat_addr,
  input logic            beat_last,
  input logic            wb_valid,
  input logic            err_valid
);

  assert_busy_R1: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> !req_ready);

  assert_first_beat_R4: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> (beat_valid && beat_addr == burst_addr));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && !beat_last) |=>
      (beat_valid && beat_addr == $past(beat_addr) + AW'(4) && beat_reg > $past(beat_reg)));

  assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    burst_valid |=> !burst_valid);

  assert_wb_with_burst_R6: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> burst_valid);

  assert_end_R7: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && beat_last) |=> (!beat_valid && req_ready));

  assert_empty_R8: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (!burst_valid && !wb_valid && !beat_valid && req_ready));

  assert_align_R9: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (beat_addr[1:0] == 2'b00));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ready) |=>
      (beat_valid && $stable(beat_addr) && $stable(beat_reg) && $stable(beat_last)));

endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.AW(AW), .REGS(REGS)) u_chk (.*);

// File: tb/tb_lsm_addr_seq.sv
module tb_lsm_addr_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_base = '0;
  logic [15:0] req_mask = '0;
  logic [2:0]  req_mode = '0;
  logic        req_load = 1'b0;
  logic        req_wb = 1'b0;
  logic        burst_valid;
  logic [31:0] burst_addr;
  logic [4:0]  burst_len;
  logic        burst_load;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [3:0]  beat_reg;
  logic [31:0] beat_addr;
  logic        beat_last;
  logic        wb_valid;
  logic [31:0] wb_base;
  logic        err_valid;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lsm_addr_seq dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Base mode from code and direction: 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before
  function automatic int eff_mode(input logic [2:0] m, input logic ld);
    case (m)
      3'd4: return ld ? 0 : 3;
      3'd5: return ld ? 1 : 2;
      3'd6: return ld ? 2 : 1;
      3'd7: return ld ? 3 : 0;
      default: return int'(m);
    endcase
  endfunction

  function automatic logic [31:0] exp_start(input logic [31:0] b, input int n, input int em);
    logic [31:0] a = {b[31:2], 2'b00};
    case (em)
      0: return a;
      1: return a + 32'd4;
      2: return a - 32'(4 * n) + 32'd4;
      default: return a - 32'(4 * n);
    endcase
  endfunction

  function automatic logic [31:0] exp_wb(input logic [31:0] b, input int n, input int em);
    logic [31:0] a = {b[31:2], 2'b00};
    return (em < 2) ? a + 32'(4 * n) : a - 32'(4 * n);
  endfunction

  task automatic run_req(input logic [31:0] base, input logic [15:0] mask, input logic [2:0] mode,
                         input logic ld, input logic wb, input bit rnd);
    int regs[16];
    int n = 0;
    int em = eff_mode(mode, ld);
    logic [31:0] st;
    int k = 0;
    bit first = 1;
    for (int i = 0; i < 16; i++) if (mask[i]) begin regs[n] = i; n++; end
    st = exp_start(base, n, em);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 idle ready", 32'(req_ready), 1);
    req_valid = 1'b1; req_base = base; req_mask = mask; req_mode = mode;
    req_load = ld; req_wb = wb;
    @(negedge clk);
    req_valid = 1'b0;
    if (n == 0) begin
      chk(err_valid == 1'b1, "R8 err pulse", 32'(err_valid), 1);
      chk(!burst_valid && !beat_valid && !wb_valid, "R8 no burst/beat/wb",
          {29'd0, burst_valid, beat_valid, wb_valid}, 0);
      @(negedge clk);
      chk(!err_valid && !beat_valid && req_ready, "R8 quiet after err",
          {29'd0, err_valid, beat_valid, req_ready}, 1);
      return;
    end
    chk(burst_valid == 1'b1, "R5 burst pulse", 32'(burst_valid), 1);
    chk(burst_addr == st, (mode < 4) ? "R2 start addr" : "R3 alias start addr", burst_addr, st);
    chk(burst_addr[1:0] == 2'b00, "R9 aligned", burst_addr, st);
    chk(32'(burst_len) == 32'(n), "R5 burst len", 32'(burst_len), 32'(n));
    chk(burst_load == ld, "R5 burst dir", 32'(burst_load), 32'(ld));
    chk(wb_valid == wb, "R6 wb flag", 32'(wb_valid), 32'(wb));
    if (wb) chk(wb_base == exp_wb(base, n, em), "R6 wb base", wb_base, exp_wb(base, n, em));
    chk(err_valid == 1'b0, "R8 no err", 32'(err_valid), 0);
    while (k < n) begin
      bit rdy;
      if (!first) chk(!burst_valid && !wb_valid, "R5 pulse one cycle",
                      {30'd0, burst_valid, wb_valid}, 0);
      first = 0;
      chk(beat_valid == 1'b1, "R4 beat valid", 32'(beat_valid), 1);
      chk(32'(beat_reg) == 32'(regs[k]), "R4 beat reg order", 32'(beat_reg), 32'(regs[k]));
      chk(beat_addr == st + 32'(4 * k), "R4 beat addr", beat_addr, st + 32'(4 * k));
      chk(beat_last == (k == n - 1), "R7 last flag", 32'(beat_last), 32'(k == n - 1));
      chk(req_ready == 1'b0, "R1 busy", 32'(req_ready), 0);
      rdy = rnd ? (($urandom % 4) != 0) : 1'b1;
      if (!rdy) begin
        beat_ready = 1'b0;
        @(negedge clk);
        chk(beat_valid && 32'(beat_reg) == 32'(regs[k]) && beat_addr == st + 32'(4 * k),
            "R10 stall hold", beat_addr, st + 32'(4 * k));
      end else begin
        beat_ready = 1'b1;
        @(negedge clk);
        k++;
      end
    end
    beat_ready = 1'b0;
    chk(!beat_valid, "R7 drop after last", 32'(beat_valid), 0);
    chk(req_ready == 1'b1, "R1 ready after last", 32'(req_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !burst_valid && !beat_valid && !wb_valid && !err_valid, "R11 reset state",
        {27'd0, req_ready, burst_valid, beat_valid, wb_valid, err_valid}, 32'h10);
    // five registers, increment-after, writeback adds 20
    run_req(32'h0000_1000, 16'h100F, 3'd0, 1'b1, 1'b1, 0);
    // every mode code with both directions
    for (int m = 0; m < 8; m++) begin
      run_req(32'h0000_8000, 16'h0A51, 3'(m), 1'b1, 1'b1, 0);
      run_req(32'h0000_8000, 16'h0A51, 3'(m), 1'b0, 1'b1, 0);
    end
    run_req(32'h0000_2000, 16'h0000, 3'd0, 1'b1, 1'b1, 0);   // empty mask
    run_req(32'h0000_3003, 16'h0003, 3'd1, 1'b0, 1'b1, 0);   // unaligned base
    run_req(32'h0000_4000, 16'hFFFF, 3'd3, 1'b0, 1'b1, 1);   // full mask, stalls
    run_req(32'h0000_0000, 16'h8000, 3'd2, 1'b1, 1'b0, 0);   // single reg, no wb
    for (int t = 0; t < 150; t++) begin
      logic [15:0] mk = 16'($urandom);
      if (t % 25 == 0) mk = '0;
      run_req($urandom, mk, 3'($urandom), 1'($urandom), 1'($urandom), 1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule